// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block collects the interrupt sources of a small multi-core cluster and turns them into one IRQ line per core. Each core has its own four timer lines, its own performance-monitor line, and a bank of word-wide inter-processor mailboxes. Any core can raise an interrupt on another core by OR-ing a word into one of that core's mailboxes. The owning core then acknowledges the interrupt by writing ones to the clear address of that mailbox. A single line from a downstream peripheral interrupt controller is shared by the whole cluster. It is steered to exactly one core, chosen by a routing register.

Software reads a per-core pending word that shows which sources are active. Separately, a per-core enable word decides which timer, mailbox and monitor sources reach that core's IRQ output. The routed peripheral line always reaches the IRQ of the core it is routed to. All registers sit on a simple single-cycle read/write bus: writes take effect at the clock edge, and reads are combinational from the address.

Top module: `core_irq_router`

## Requirements
- R1: Bits 3:0 of the pending word of core N (read at address 0x00+4N) show the four timer lines of core N, bit k being line 4N+k of `timer_irq_i`.
- R2: Pending bit 4+M of core N is 1 exactly while mailbox M of core N holds a nonzero word.
- R3: A write to 0x40+16N+4M ORs the write data into mailbox M of core N; a read of that address returns the mailbox word.
- R4: A write to 0x80+16N+4M clears each mailbox bit written as 1 and leaves bits written as 0 unchanged; a read of that address returns the mailbox word.
- R5: Register 0x10 bits 1:0 select one core; the peripheral line appears as pending bit 8 of that core only, and bit 8 of every other core reads 0. After reset the selection is core 0.
- R6: Pending bit 9 of core N shows `pmu_irq_i[N]`.
- R7: The enable register of core N at 0x20+4N holds bits 3:0 for the timers, bits 7:4 for the mailboxes and bit 9 for the monitor. Bit 8 always reads 0. `irq_o[N]` is the OR of core N's pending bits masked by its enable bits, with bit 8 always passed.
- R8: Timer interrupts enabled on several cores raise all of those cores' IRQ outputs in the same cycle.
- R9: After reset all mailboxes, enable registers and the route register read 0. With idle inputs, every pending word reads 0 and every IRQ output is 0.
- R10: Writes to a pending-word address change no register: the enable, route and mailbox readbacks and the pending word itself are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_irq_i | input | NUM_CORES*4 | Timer lines, four per core |
| pmu_irq_i | input | NUM_CORES | Performance-monitor line per core |
| periph_irq_i | input | 1 | Aggregated line from the peripheral interrupt controller |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 8 | Byte address, word aligned |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i` |
| irq_o | output | NUM_CORES | IRQ output per core |

## Verification
The hardest situation to reach is a mailbox word that is partly cleared and partly set again, while other sources are also pending on the same core. In that state the pending bit and the IRQ must follow the word's residue, not the last write. The stimulus goes there by layering set writes of different bit groups, then a clear with zero data, then a clear of only part of the word. After each step the mailbox and pending readbacks are compared against a reference model. The routing register is also moved while the peripheral line is held high. This shows that bit 8 moves between cores in a single cycle and never shows on two cores at once.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   localparam int SRC_PER_CORE = 10;
   localparam int TMR_BASE     = 0;
   localparam int TMR_LINES    = 4;
   localparam int MBX_BASE     = 4;
   localparam int PERIPH_BIT   = 8;
   localparam int PMU_BIT      = 9;

   localparam logic [1:0] REGION_CTRL = 2'b00;
   localparam logic [1:0] REGION_MSET = 2'b01;
   localparam logic [1:0] REGION_MCLR = 2'b10;

   localparam logic [1:0] CTRL_PEND  = 2'b00;
   localparam logic [1:0] CTRL_ROUTE = 2'b01;
   localparam logic [1:0] CTRL_ENAB  = 2'b10;

   typedef struct packed {
      logic       aligned;
      logic [1:0] region;
      logic [1:0] group;
      logic [1:0] index;
   } addr_fields_t;

   function automatic addr_fields_t split_addr(input logic [7:0] a);
      addr_fields_t f;
      f.aligned = (a[1:0] == 2'b00);
      f.region  = a[7:6];
      f.group   = a[5:4];
      f.index   = a[3:2];
      return f;
   endfunction
endpackage

// File: rtl/irq_mbox_bank.sv
module irq_mbox_bank #(
   parameter int NUM_MBOX = 4,
   parameter int MBOX_W   = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_MBOX-1:0]        set_we_i,
   input  logic [NUM_MBOX-1:0]        clr_we_i,
   input  logic [MBOX_W-1:0]          wdata_i,
   output logic [NUM_MBOX*MBOX_W-1:0] words_o,
   output logic [NUM_MBOX-1:0]        nz_o
);
   for (genvar m = 0; m < NUM_MBOX; m++) begin : g_word
      logic [MBOX_W-1:0] word_q;
      logic [MBOX_W-1:0] clr_bits, set_bits;
      assign clr_bits = clr_we_i[m] ? wdata_i : '0;
      assign set_bits = set_we_i[m] ? wdata_i : '0;
      always_ff @(posedge clk) begin
         if (!rst_n) word_q <= '0;
         else        word_q <= (word_q & ~clr_bits) | set_bits;
      end
      assign words_o[m*MBOX_W +: MBOX_W] = word_q;
      assign nz_o[m] = |word_q;
   end
endmodule

// File: rtl/irq_core_pend.sv
module irq_core_pend #(
   parameter int NUM_MBOX = 4
) (
   input  logic [3:0]                                  timer_i,
   input  logic [NUM_MBOX-1:0]                         mbox_nz_i,
   input  logic                                        periph_i,
   input  logic                                        pmu_i,
   input  logic [irq_router_pkg::SRC_PER_CORE-1:0]     enable_i,
   output logic [irq_router_pkg::SRC_PER_CORE-1:0]     pend_o,
   output logic                                        irq_o
);
   import irq_router_pkg::*;

   logic [SRC_PER_CORE-1:0] pass_mask;

   always_comb begin
      pend_o = '0;
      pend_o[TMR_BASE +: TMR_LINES] = timer_i;
      pend_o[MBX_BASE +: NUM_MBOX]  = mbox_nz_i;
      pend_o[PERIPH_BIT]            = periph_i;
      pend_o[PMU_BIT]               = pmu_i;
   end

   always_comb begin
      pass_mask = enable_i;
      pass_mask[PERIPH_BIT] = 1'b1;
   end

   assign irq_o = |(pend_o & pass_mask);
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router #(
   parameter int NUM_CORES = 4,
   parameter int NUM_MBOX  = 4,
   parameter int MBOX_W    = 32,
   parameter int DATA_W    = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_CORES*4-1:0] timer_irq_i,
   input  logic [NUM_CORES-1:0]   pmu_irq_i,
   input  logic                   periph_irq_i,
   input  logic                   bus_wr_i,
   input  logic [7:0]             bus_addr_i,
   input  logic [DATA_W-1:0]      bus_wdata_i,
   output logic [DATA_W-1:0]      bus_rdata_o,
   output logic [NUM_CORES-1:0]   irq_o
);
   import irq_router_pkg::*;

   localparam int PEND_W = SRC_PER_CORE;
   localparam int CSEL_W = 2;
   localparam int BANK_W = NUM_MBOX * MBOX_W;
   localparam logic [PEND_W-1:0] EN_MASK =
      PEND_W'(10'h20F | (((10'h1 << NUM_MBOX) - 10'h1) << MBX_BASE));

   if (NUM_CORES < 1 || NUM_CORES > 4) begin : g_bad_cores
      $error("NUM_CORES must be 1 to 4");
   end
   if (NUM_MBOX < 1 || NUM_MBOX > 4) begin : g_bad_mbox
      $error("NUM_MBOX must be 1 to 4");
   end
   if (MBOX_W < 1 || MBOX_W > DATA_W || DATA_W < PEND_W) begin : g_bad_width
      $error("need MBOX_W <= DATA_W and DATA_W >= pending width");
   end

   addr_fields_t fa;
   assign fa = split_addr(bus_addr_i);

   logic                          wr_ok;
   logic [CSEL_W-1:0]             route_q;
   logic [NUM_CORES*PEND_W-1:0]   en_flat;
   logic [NUM_CORES*PEND_W-1:0]   pend_flat;
   logic [NUM_CORES*BANK_W-1:0]   mbox_flat;

   assign wr_ok = bus_wr_i && fa.aligned;

   always_ff @(posedge clk) begin
      if (!rst_n)
         route_q <= '0;
      else if (wr_ok && fa.region == REGION_CTRL && fa.group == CTRL_ROUTE && fa.index == 2'd0)
         route_q <= bus_wdata_i[CSEL_W-1:0];
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic [NUM_MBOX-1:0] set_we, clr_we, nz;
      logic [PEND_W-1:0]   en_q;
      logic                periph_here;

      for (genvar m = 0; m < NUM_MBOX; m++) begin : g_we
         assign set_we[m] = wr_ok && fa.region == REGION_MSET &&
                            fa.group == 2'(c) && fa.index == 2'(m);
         assign clr_we[m] = wr_ok && fa.region == REGION_MCLR &&
                            fa.group == 2'(c) && fa.index == 2'(m);
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            en_q <= '0;
         else if (wr_ok && fa.region == REGION_CTRL && fa.group == CTRL_ENAB && fa.index == 2'(c))
            en_q <= bus_wdata_i[PEND_W-1:0] & EN_MASK;
      end
      assign en_flat[c*PEND_W +: PEND_W] = en_q;
      assign periph_here = periph_irq_i && (route_q == CSEL_W'(c));

      irq_mbox_bank #(.NUM_MBOX(NUM_MBOX), .MBOX_W(MBOX_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_we_i (set_we),
         .clr_we_i (clr_we),
         .wdata_i  (bus_wdata_i[MBOX_W-1:0]),
         .words_o  (mbox_flat[c*BANK_W +: BANK_W]),
         .nz_o     (nz)
      );

      irq_core_pend #(.NUM_MBOX(NUM_MBOX)) u_pend (
         .timer_i   (timer_irq_i[c*4 +: 4]),
         .mbox_nz_i (nz),
         .periph_i  (periph_here),
         .pmu_i     (pmu_irq_i[c]),
         .enable_i  (en_q),
         .pend_o    (pend_flat[c*PEND_W +: PEND_W]),
         .irq_o     (irq_o[c])
      );
   end

   always_comb begin
      bus_rdata_o = '0;
      if (fa.aligned) begin
         case (fa.region)
            REGION_CTRL: begin
               case (fa.group)
                  CTRL_PEND: begin
                     for (int c = 0; c < NUM_CORES; c++)
                        if (fa.index == 2'(c))
                           bus_rdata_o = DATA_W'(pend_flat[c*PEND_W +: PEND_W]);
                  end
                  CTRL_ROUTE: begin
                     if (fa.index == 2'd0) bus_rdata_o = DATA_W'(route_q);
                  end
                  CTRL_ENAB: begin
                     for (int c = 0; c < NUM_CORES; c++)
                        if (fa.index == 2'(c))
                           bus_rdata_o = DATA_W'(en_flat[c*PEND_W +: PEND_W]);
                  end
                  default: bus_rdata_o = '0;
               endcase
            end
            REGION_MSET, REGION_MCLR: begin
               for (int c = 0; c < NUM_CORES; c++)
                  for (int m = 0; m < NUM_MBOX; m++)
                     if (fa.group == 2'(c) && fa.index == 2'(m))
                        bus_rdata_o = DATA_W'(mbox_flat[c*BANK_W + m*MBOX_W +: MBOX_W]);
            end
            default: bus_rdata_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker #(
   parameter int NUM_CORES = 4,
   parameter int NUM_MBOX  = 4,
   parameter int MBOX_W    = 32,
   parameter int DATA_W    = 32
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                periph_irq_i,
   input logic                                bus_wr_i,
   input logic [7:0]                          bus_addr_i,
   input logic [DATA_W-1:0]                   bus_wdata_i,
   input logic [NUM_CORES-1:0]                irq_o,
   input logic [1:0]                          route_q,
   input logic [NUM_CORES*10-1:0]             en_flat,
   input logic [NUM_CORES*10-1:0]             pend_flat,
   input logic [NUM_CORES*NUM_MBOX*MBOX_W-1:0] mbox_flat
);
   logic [NUM_CORES-1:0] periph_bits;
   for (genvar c = 0; c < NUM_CORES; c++) begin : g_pb
      assign periph_bits[c] = pend_flat[c*10 + 8];
   end

   assert_periph_one_core_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(periph_bits));

   assert_route_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr_i && bus_addr_i == 8'h10) |=> $stable(route_q));

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o[c] |-> (periph_irq_i || en_flat[c*10 +: 10] != '0));

      for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mb
         localparam int K = c*NUM_MBOX + m;

         assert_mbox_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_i && bus_addr_i == 8'(8'h40 + 16*c + 4*m)) |=>
            ((mbox_flat[K*MBOX_W +: MBOX_W] & $past(bus_wdata_i[MBOX_W-1:0]))
               == $past(bus_wdata_i[MBOX_W-1:0])));

         assert_mbox_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_i && bus_addr_i == 8'(8'h80 + 16*c + 4*m)) |=>
            ((mbox_flat[K*MBOX_W +: MBOX_W] & $past(bus_wdata_i[MBOX_W-1:0])) == '0));

         assert_mbox_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
            pend_flat[c*10 + 4 + m] == (mbox_flat[K*MBOX_W +: MBOX_W] != '0));
      end
   end
endmodule

bind core_irq_router irq_router_checker #(
   .NUM_CORES(NUM_CORES), .NUM_MBOX(NUM_MBOX), .MBOX_W(MBOX_W), .DATA_W(DATA_W)
) u_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .periph_irq_i (periph_irq_i),
   .bus_wr_i     (bus_wr_i),
   .bus_addr_i   (bus_addr_i),
   .bus_wdata_i  (bus_wdata_i),
   .irq_o        (irq_o),
   .route_q      (route_q),
   .en_flat      (en_flat),
   .pend_flat    (pend_flat),
   .mbox_flat    (mbox_flat)
);

// File: tb/core_irq_router_bench.sv
module core_irq_router_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] timer_r = '0;
   logic [3:0]  pmu_r = '0;
   logic        periph_r = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] mb [4][4];
   logic [9:0]  en [4];
   int          route;

   always #5 clk = ~clk;

   core_irq_router u_core_irq_router (
      .clk(clk), .rst_n(rst_n), .timer_irq_i(timer_r), .pmu_irq_i(pmu_r),
      .periph_irq_i(periph_r), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq));

   function automatic logic [9:0] exp_pend(int c);
      logic [9:0] p = '0;
      p[3:0] = timer_r[c*4 +: 4];
      for (int m = 0; m < 4; m++) p[4+m] = (mb[c][m] != 0);
      p[8] = periph_r && (route == c);
      p[9] = pmu_r[c];
      return p;
   endfunction

   function automatic logic exp_irq(int c);
      return |(exp_pend(c) & (en[c] | 10'h100));
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   always @(posedge clk) begin
      if (rst_n && !done) begin
         #4;
         for (int c = 0; c < 4; c++) check("R7 irq_o", 32'(irq[c]), 32'(exp_irq(c)));
      end
   end

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
      if (a == 8'h10) route = int'(d[1:0]);
      else if (a >= 8'h20 && a <= 8'h2C) en[(a - 8'h20) >> 2] = d[9:0] & 10'h2FF;
      else if (a >= 8'h40 && a <= 8'h7C) mb[(a - 8'h40) >> 4][((a - 8'h40) >> 2) & 3] |= d;
      else if (a >= 8'h80 && a <= 8'hBC) mb[(a - 8'h80) >> 4][((a - 8'h80) >> 2) & 3] &= ~d;
   endtask

   task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic rd_pend(string req, int c);
      rd(req, 8'(4*c), 32'(exp_pend(c)));
   endtask

   initial begin
      #(200000 * 10);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      route = 0;
      for (int c = 0; c < 4; c++) begin
         en[c] = '0;
         for (int m = 0; m < 4; m++) mb[c][m] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      for (int c = 0; c < 4; c++) begin
         rd("R9 pending", 8'(4*c), 32'h0);
         rd("R9 enable", 8'(8'h20 + 4*c), 32'h0);
      end
      rd("R9 route", 8'h10, 32'h0);
      rd("R9 mailbox", 8'h84, 32'h0);
      check("R9 irq", 32'(irq), 32'h0);

      // R1 timers on core 0 and core 3
      @(negedge clk); timer_r = 16'h4004;
      rd_pend("R1 timer pending core0", 0);
      rd("R1 timer pending core3", 8'h0C, 32'h004);
      wr(8'h20, 32'h00F);
      rd("R7 enable readback", 8'h20, 32'h00F);

      // R8 timers on all cores at once
      @(negedge clk); timer_r = 16'h1248;
      for (int c = 0; c < 4; c++) wr(8'(8'h20 + 4*c), 32'h00F);
      @(negedge clk); #1;
      check("R8 all cores irq", 32'(irq), 32'hF);
      @(negedge clk); timer_r = '0;

      // R2/R4 mailbox round trip: core 1 sets bit 3 of core 2 mailbox 0
      wr(8'h60, 32'h8);
      rd("R2 pending bit4 core2", 8'h08, 32'h010);
      wr(8'h28, 32'h0F0);
      @(negedge clk); #1;
      check("R2 irq core2", 32'(irq[2]), 32'h1);
      wr(8'hA0, 32'h0);
      rd("R4 zero clear keeps word", 8'hA0, 32'h8);
      wr(8'hA0, 32'h8);
      rd("R4 cleared word", 8'hA0, 32'h0);
      rd("R2 pending dropped", 8'h08, 32'h0);
      @(negedge clk); #1;
      check("R4 irq core2 dropped", 32'(irq[2]), 32'h0);

      // R3 OR accumulate, R4 partial clear
      wr(8'h74, 32'h0000_0003);
      wr(8'h74, 32'h8000_0010);
      rd("R3 or-in readback set addr", 8'h74, 32'h8000_0013);
      wr(8'hB4, 32'h0000_0011);
      rd("R4 partial clear", 8'hB4, 32'h8000_0002);
      rd("R2 pending bit5 core3", 8'h0C, 32'h020);

      // R5 routing of the peripheral line
      @(negedge clk); periph_r = 1'b1;
      for (int c = 0; c < 4; c++) rd_pend("R5 route core0", c);
      rd("R5 core0 bit8", 8'h00, 32'h100);
      wr(8'h10, 32'h3);
      rd("R5 route readback", 8'h10, 32'h3);
      rd("R5 core0 bit8 gone", 8'h00, 32'h0);
      for (int c = 0; c < 4; c++) rd_pend("R5 route core3", c);
      @(negedge clk); periph_r = 1'b0;

      // R6 monitor line with and without enable
      @(negedge clk); pmu_r = 4'b0010;
      rd("R6 pmu pending core1", 8'h04, 32'h200);
      wr(8'h24, 32'h000);
      @(negedge clk); #1;
      check("R7 pmu masked", 32'(irq[1]), 32'h0);
      wr(8'h24, 32'h200);
      @(negedge clk); #1;
      check("R6 pmu irq", 32'(irq[1]), 32'h1);
      @(negedge clk); pmu_r = '0;

      // R7 bit 8 of enable ignored
      wr(8'h20, 32'hFFFF_FFFF);
      rd("R7 enable bit8 reads 0", 8'h20, 32'h2FF);

      // R10 writes to pending addresses change nothing
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h00, 32'h3);
      rd("R10 enable core1 unchanged", 8'h24, 32'h200);
      rd("R10 route unchanged", 8'h10, 32'h3);
      rd("R10 mailbox unchanged", 8'h74, 32'h8000_0002);
      for (int c = 0; c < 4; c++) rd_pend("R10 pending follows inputs", c);

      repeat (3) @(negedge clk);
      done = 1'b1;
      #10;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule